// File: doc/BRIEF.md
# Dual-Mode Two-Wire Serial Slave Front End

This block is the bus-facing half of a two-wire memory slave. It oversamples the clock and data lines of an I2C/SMBus bus with the system clock and finds START, repeated START and STOP conditions. It receives the address byte, checks it against a fixed prefix and two strap pins, and then moves bytes in either direction, most significant bit first. It acknowledges a byte by pulling the data line low through an open-drain enable. It never drives the clock line.

Towards the memory controller it delivers a strobe for each accepted byte and flags the byte that carries the memory address. It also reports the transfer direction and the latched half-select bit, and asks for the next read byte with a one-cycle request. The controller answers with a busy level, an accept level for data bytes and the byte to transmit. A mode bit, written by the controller, picks plain I2C behaviour or SMBus behaviour. The modes differ in how a busy device answers and in whether a stuck-bus timeout is active.

Top module: `dual_serial_slave`

## Requirements
- R1: An address byte is acknowledged only when bits 7..4 equal 1010, bit 3 equals `addr_pin_hi` and bit 2 equals `addr_pin_lo`; a non-matching address leaves `sda_oe` low for the rest of the transfer.
- R2: Bit 1 of an acknowledged write address is latched into `half_sel` (0 lower half, 1 upper half); a read address leaves `half_sel` unchanged.
- R3: Written bytes are shifted in MSB first on rising SCL edges; each acknowledged byte after the address gives one `rx_valid` pulse with the byte on `rx_data`, and `rx_first` is 1 only for the first byte after a write address.
- R4: In a read, `tx_data` is loaded on the SCL fall that ends the acknowledge clock and sent MSB first; a master ACK (SDA low) raises `rd_req` and continues with the next byte, a master NACK ends the transfer.
- R5: `sda_oe` changes only while the synchronised SCL is low, except when a timeout releases it.
- R6: In I2C mode (`smbus_mode` = 0) an address byte is NACKed while `busy` is 1.
- R7: In SMBus mode a matching address is always ACKed; while `busy` is 1 the memory-address byte is ACKed only if it is 0x7A with `half_sel` = 0.
- R8: A data byte after the memory-address byte is ACKed only when `accept` is 1 and `busy` is 0.
- R9: A STOP anywhere releases `sda_oe` and returns to idle, so later bytes without a START are ignored; a START anywhere, also in the middle of a byte, restarts address reception.
- R10: In SMBus mode, an open transfer in which SCL keeps one level, or SDA stays low, for CYC_PER_MS x TIMEOUT_MS cycles is closed as if by a STOP; in I2C mode no timeout applies.
- R11: `smbus_mode` is 0 after reset, takes `mode_d` on a cycle with `mode_we` = 1 and holds otherwise.
- R12: Synchronous active-low `rst_n` clears `sda_oe`, `smbus_mode`, `half_sel` and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset (master reset) |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pin_hi | input | 1 | Strap compared with address bit 3 |
| addr_pin_lo | input | 1 | Strap compared with address bit 2 |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_d | input | 1 | New mode bit value, 1 = SMBus |
| smbus_mode | output | 1 | Current mode bit |
| busy | input | 1 | Controller is in a program cycle |
| accept | input | 1 | Controller accepts data bytes |
| tx_data | input | 8 | Byte to send on a read |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rx_valid | output | 1 | One-cycle strobe for an acknowledged byte |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | The strobed byte is the memory address |
| xfer_read | output | 1 | Direction of the current transfer |
| half_sel | output | 1 | Latched memory half select |

## Verification
A pin edge reaches the logic after the two synchroniser flops and the edge register, so `sda_oe`, `rx_valid` and `rd_req` react about three system cycles after the SCL fall or rise that triggers them. The bench holds every SCL phase for eight cycles and samples the bus data line halfway through the SCL high phase, well after the response has settled and before the master moves again. Port levels such as `half_sel` and `smbus_mode` are read only once a STOP has been followed by several idle cycles. The timeout cases hold SCL for more than the scaled window before the next byte is tried.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the two-wire slave front end.
package sbus_pkg;
    // Byte engine states.
    typedef enum logic [2:0] {
        ST_IDLE,  // no transfer open
        ST_RX,    // shifting in a byte
        ST_ACK,   // acknowledge clock after a received byte
        ST_TX,    // shifting out a byte
        ST_MACK,  // master acknowledge clock after a sent byte
        ST_SKIP   // not addressed or refused; wait for START/STOP
    } eng_state_t;

    // Which byte of a write transfer is being received.
    typedef enum logic [1:0] {
        PH_ADDR,  // slave address byte
        PH_MEM,   // memory address byte
        PH_DATA   // payload bytes
    } byte_phase_t;

    localparam logic [3:0] DEV_PREFIX    = 4'b1010;
    localparam logic [7:0] CTRL_REG_ADDR = 8'h7A;
endpackage

// File: rtl/sbus_line_cond.sv
`timescale 1ns/1ps
// Synchronises the bus clock and data lines into the system clock domain
// and flags SCL edges plus START and STOP conditions.
// Assumes STAGES >= 2 and that each bus phase lasts several system cycles.
module sbus_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Edge and bus condition decode on the synchronised lines.
    always_comb begin
        scl_s    = scl_sh[STAGES-1];
        sda_s    = sda_sh[STAGES-1];
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_p  = scl_s & scl_d & sda_d & ~sda_s;
        stop_p   = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/sbus_stuck_timer.sv
`timescale 1ns/1ps
// Stuck-bus watchdog: one counter per watched condition, picked by a generate
// loop. Watcher 0 restarts on any SCL edge, watcher 1 restarts while SDA is high.
// Assumes the window CYC_PER_MS * TIMEOUT_MS fits in 31 bits.
module sbus_stuck_timer #(
    parameter int CYC_PER_MS = 200_000,
    parameter int TIMEOUT_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_edge,
    input  logic sda_s,
    output logic expired
);
    localparam int LIMIT = CYC_PER_MS * TIMEOUT_MS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_W = CW'(LIMIT);

    logic [1:0] clr;
    logic [1:0] hit;

    assign clr = {sda_s, scl_edge};

    for (genvar g = 0; g < 2; g++) begin : g_watch
        logic [CW-1:0] cnt;
        // Count cycles without the restart event, saturating at the window.
        always_ff @(posedge clk) begin
            if (!rst_n || !enable || clr[g]) begin
                cnt <= '0;
            end else if (cnt != LIMIT_W) begin
                cnt <= cnt + CW'(1);
            end
        end
        assign hit[g] = (cnt == LIMIT_W);
    end

    assign expired = enable & (|hit);
endmodule

// File: rtl/sbus_byte_engine.sv
`timescale 1ns/1ps
// Byte-level slave engine: address match, receive and transmit shifting,
// acknowledge decisions for both bus modes and half-select latching.
// Assumes edge and condition pulses from sbus_line_cond; controller inputs
// busy/accept are sampled on the SCL fall that opens an acknowledge clock,
// tx_data is sampled on the SCL fall that starts a byte.
module sbus_byte_engine
    import sbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       tmo,
    input  logic       pin_hi,
    input  logic       pin_lo,
    input  logic       smbus_mode,
    input  logic       busy,
    input  logic       accept,
    input  logic [7:0] tx_data,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_first,
    output logic       rd_req,
    output logic       xfer_read,
    output logic       half_sel,
    output logic       active
);
    eng_state_t  st;
    byte_phase_t ph;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        ack_q;
    logic        ack_drv;
    logic        mack_ok;
    logic        addr_hit;
    logic        ack_now;

    // Acknowledge decision for the byte now held in the shift register.
    always_comb begin
        addr_hit = (shreg[7:4] == DEV_PREFIX) && (shreg[3] == pin_hi) && (shreg[2] == pin_lo);
        unique case (ph)
            PH_ADDR: ack_now = addr_hit && (smbus_mode || !busy);
            PH_MEM:  ack_now = !(smbus_mode && busy) || ((shreg == CTRL_REG_ADDR) && !half_sel);
            default: ack_now = accept && !busy;
        endcase
    end

    assign active = (st != ST_IDLE);

    // Main engine: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        rd_req   <= 1'b0;
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            ack_q     <= 1'b0;
            ack_drv   <= 1'b0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            rx_data   <= '0;
            rx_first  <= 1'b0;
            xfer_read <= 1'b0;
            half_sel  <= 1'b0;
        end else if (stop_p || tmo) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_p) begin
            st     <= ST_RX;
            ph     <= PH_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            st      <= ST_ACK;
                            ack_drv <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall && !ack_drv) begin
                        ack_drv <= 1'b1;
                        ack_q   <= ack_now;
                        sda_oe  <= ack_now;
                        if (ack_now) begin
                            if (ph == PH_ADDR) begin
                                xfer_read <= shreg[0];
                                if (!shreg[0]) half_sel <= shreg[1];
                                if (shreg[0]) rd_req <= 1'b1;
                            end else begin
                                rx_valid <= 1'b1;
                                rx_data  <= shreg;
                                rx_first <= (ph == PH_MEM);
                            end
                        end
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (!ack_q) begin
                            sda_oe <= 1'b0;
                            st     <= ST_SKIP;
                        end else if (ph == PH_ADDR && xfer_read) begin
                            shreg  <= tx_data;
                            sda_oe <= ~tx_data[7];
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_RX;
                            ph     <= (ph == PH_ADDR) ? PH_MEM : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe  <= 1'b0;
                            mack_ok <= 1'b0;
                            st      <= ST_MACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            st <= ST_SKIP;
                        end else begin
                            mack_ok <= 1'b1;
                            rd_req  <= 1'b1;
                        end
                    end else if (scl_fall && mack_ok) begin
                        shreg  <= tx_data;
                        sda_oe <= ~tx_data[7];
                        bitcnt <= '0;
                        st     <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dual_serial_slave.sv
`timescale 1ns/1ps
// Top of the two-wire slave front end. Ties together line conditioning,
// the stuck-bus timer and the byte engine, and holds the bus mode bit.
// Assumes the pads already remove analog glitches; SCL is never driven.
module dual_serial_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int CYC_PER_MS  = 200_000,
    parameter int TIMEOUT_MS  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       addr_pin_hi,
    input  logic       addr_pin_lo,
    input  logic       mode_we,
    input  logic       mode_d,
    output logic       smbus_mode,
    input  logic       busy,
    input  logic       accept,
    input  logic [7:0] tx_data,
    output logic       rd_req,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_first,
    output logic       xfer_read,
    output logic       half_sel
);
    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_p;
    logic stop_p;
    logic tmo;
    logic active;

    // Bus mode bit: I2C after reset, changed only by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smbus_mode <= 1'b0;
        end else if (mode_we) begin
            smbus_mode <= mode_d;
        end
    end

    sbus_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    sbus_stuck_timer #(.CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (smbus_mode & active),
        .scl_edge (scl_rise | scl_fall),
        .sda_s    (sda_s),
        .expired  (tmo)
    );

    sbus_byte_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_p    (start_p),
        .stop_p     (stop_p),
        .tmo        (tmo),
        .pin_hi     (addr_pin_hi),
        .pin_lo     (addr_pin_lo),
        .smbus_mode (smbus_mode),
        .busy       (busy),
        .accept     (accept),
        .tx_data    (tx_data),
        .sda_oe     (sda_oe),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_first   (rx_first),
        .rd_req     (rd_req),
        .xfer_read  (xfer_read),
        .half_sel   (half_sel),
        .active     (active)
    );
endmodule

// File: rtl/dual_serial_slave_chk.sv
`timescale 1ns/1ps
// Property checker for dual_serial_slave, attached through bind.
// Assumes rst_n is driven low from time zero.
module dual_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic smbus_mode,
    input logic mode_we,
    input logic scl_s,
    input logic stop_p,
    input logic tmo,
    input logic half_sel,
    input logic xfer_read,
    input logic rd_req
);
    // R5: the data line enable moves only while SCL is low, timeout aside.
    a_r5_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(tmo)) |-> !scl_s);

    // R9: a STOP releases the data line.
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_oe);

    // R10: the timeout fires only in SMBus mode and releases the line.
    a_r10_timeout_smbus_only: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> smbus_mode);
    a_r10_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !sda_oe);

    // R11: without a write strobe the mode bit holds.
    a_r11_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(smbus_mode));

    // R2: the half select never changes on behalf of a read transfer.
    a_r2_half_not_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        (half_sel != $past(half_sel)) |-> !xfer_read);

    // R4: read-byte requests belong to read transfers.
    a_r4_rdreq_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> xfer_read);

    // R12: reset clears the bus enable, mode bit and half select.
    a_r12_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !smbus_mode && !half_sel));
endmodule

bind dual_serial_slave dual_serial_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe),
    .smbus_mode (smbus_mode),
    .mode_we    (mode_we),
    .scl_s      (scl_s),
    .stop_p     (stop_p),
    .tmo        (tmo),
    .half_sel   (half_sel),
    .xfer_read  (xfer_read),
    .rd_req     (rd_req)
);

// File: tb/dual_serial_slave_bench.sv
`timescale 1ns/1ps
// Self-checking bench: bit-banged bus master plus a small controller model.
module dual_serial_slave_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       mode_we = 1'b0;
    logic       mode_d = 1'b0;
    logic       busy = 1'b0;
    logic       accept = 1'b1;
    logic [7:0] tx_data = 8'h3C;
    logic       sda_oe, smbus_mode, rd_req, rx_valid, rx_first, xfer_read, half_sel;
    logic [7:0] rx_data;
    logic       sda_line;
    int         n_tests = 0;
    int         n_fail = 0;
    int         rx_cnt = 0;
    logic [7:0] last_rx = 8'h00;
    logic       last_first = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    dual_serial_slave #(.CYC_PER_MS(100), .TIMEOUT_MS(3)) u_dual_serial_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_pin_hi(1'b1), .addr_pin_lo(1'b0), .mode_we(mode_we), .mode_d(mode_d),
        .smbus_mode(smbus_mode), .busy(busy), .accept(accept), .tx_data(tx_data),
        .rd_req(rd_req), .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .xfer_read(xfer_read), .half_sel(half_sel)
    );

    // Controller model: records strobed bytes, advances the read byte on request.
    always @(posedge clk) begin
        if (rx_valid) begin
            rx_cnt     <= rx_cnt + 1;
            last_rx    <= rx_data;
            last_first <= rx_first;
        end
        if (rd_req) tx_data <= tx_data + 8'h11;
    end

    // Vector table: [10] SMBus mode, [9] busy, [8:1] address byte, [0] expected ACK.
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 1'b0, 8'hA8, 1'b1},
        {1'b0, 1'b0, 8'hAA, 1'b1},
        {1'b0, 1'b0, 8'hA0, 1'b0},
        {1'b0, 1'b0, 8'hAC, 1'b0},
        {1'b0, 1'b0, 8'hB8, 1'b0},
        {1'b0, 1'b1, 8'hA8, 1'b0},
        {1'b1, 1'b1, 8'hA8, 1'b1},
        {1'b1, 1'b0, 8'hAC, 1'b0}
    };

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic v);
        @(negedge clk);
        mode_we = 1'b1;
        mode_d  = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wt(H);
            scl_m = 1'b1; wt(H);
        end
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H / 2);
        ack = ~sda_line;
        wt(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wt(H);
            scl_m = 1'b1; wt(H / 2);
            b[i] = sda_line;
            wt(H / 2);
            scl_m = 1'b0;
        end
        send_bit(~mack);
        sda_m = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic [7:0] tx0;
        int         cnt0;

        wt(5);
        rst_n = 1'b1;
        wt(3);
        check("R12 reset sda_oe", sda_oe, 0);
        check("R12 reset mode", smbus_mode, 0);
        check("R11 mode after reset", smbus_mode, 0);
        check("R12 reset half_sel", half_sel, 0);

        // R1 R6 R7: address match under both modes and busy levels.
        for (int v = 0; v < 8; v++) begin
            set_mode(VEC[v][10]);
            busy = VEC[v][9];
            bus_start();
            write_byte(VEC[v][8:1], ack);
            check($sformatf("R1/R6/R7 vector %0d addr %0h", v, VEC[v][8:1]), ack, VEC[v][0]);
            bus_stop();
            wt(4);
        end
        set_mode(1'b0);
        check("R11 mode written back to I2C", smbus_mode, 0);
        busy = 1'b0;
        accept = 1'b1;

        // R3 R8: write transfer, MSB first, first-byte flag, accept gating.
        cnt0 = rx_cnt;
        bus_start();
        write_byte(8'hA8, ack);
        check("R1 write addr ack", ack, 1);
        write_byte(8'h10, ack);
        check("R3 mem byte ack", ack, 1);
        wt(2);
        check("R3 mem byte data", last_rx, 8'h10);
        check("R3 mem byte first flag", last_first, 1);
        write_byte(8'h4B, ack);
        check("R8 data ack with accept", ack, 1);
        wt(2);
        check("R3 data msb first", last_rx, 8'h4B);
        check("R3 data first flag", last_first, 0);
        accept = 1'b0;
        write_byte(8'h33, ack);
        check("R8 data nack without accept", ack, 0);
        wt(2);
        check("R8 no strobe for refused byte", rx_cnt - cnt0, 2);
        accept = 1'b1;
        busy = 1'b1;
        write_byte(8'h34, ack);
        check("R8 data nack while busy", ack, 0);
        busy = 1'b0;
        bus_stop();
        wt(4);

        // R2: write with half 1, then a read with P0 = 0 keeps it.
        bus_start();
        write_byte(8'hAA, ack);
        check("R2 upper-half write ack", ack, 1);
        write_byte(8'h00, ack);
        bus_stop();
        wt(4);
        check("R2 half latched from write", half_sel, 1);

        // R4: read two bytes, master ACK then NACK.
        tx0 = tx_data;
        bus_start();
        write_byte(8'hA9, ack);
        check("R4 read addr ack", ack, 1);
        read_byte(1'b1, rb);
        check("R4 first read byte", rb, tx0 + 8'h11);
        read_byte(1'b0, rb);
        check("R4 second read byte after master ack", rb, tx0 + 8'h22);
        bus_stop();
        wt(4);
        check("R2 read ignores its half bit", half_sel, 1);
        check("R4 no request after master nack", tx_data, tx0 + 8'h22);

        bus_start();
        write_byte(8'hA8, ack);
        bus_stop();
        wt(4);
        check("R2 half back to lower", half_sel, 0);

        // R9: START in the middle of a byte restarts address reception.
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        write_byte(8'hA8, ack);
        check("R9 address after mid-byte start", ack, 1);
        write_byte(8'h20, ack);
        bus_stop();
        wt(4);

        // R9: after STOP, a byte without START is ignored.
        cnt0 = rx_cnt;
        scl_m = 1'b0; wt(H);
        write_byte(8'h55, ack);
        check("R9 byte after stop not acked", ack, 0);
        check("R9 byte after stop not strobed", rx_cnt - cnt0, 0);
        bus_stop();
        wt(4);

        // R7: SMBus busy handling of the memory-address and data bytes.
        set_mode(1'b1);
        busy = 1'b1;
        cnt0 = rx_cnt;
        bus_start();
        write_byte(8'hA8, ack);
        check("R7 smbus busy addr ack", ack, 1);
        write_byte(8'h7A, ack);
        check("R7 busy control address acked", ack, 1);
        write_byte(8'h01, ack);
        check("R7 busy data nack", ack, 0);
        bus_stop();
        wt(4);
        check("R7 only control address strobed", rx_cnt - cnt0, 1);
        bus_start();
        write_byte(8'hA8, ack);
        write_byte(8'h10, ack);
        check("R7 busy other memory address nack", ack, 0);
        bus_stop();
        wt(4);
        bus_start();
        write_byte(8'hAA, ack);
        write_byte(8'h7A, ack);
        check("R7 busy control address upper half nack", ack, 0);
        bus_stop();
        wt(4);
        busy = 1'b0;

        // R10: SMBus timeout closes a stalled transfer.
        cnt0 = rx_cnt;
        bus_start();
        write_byte(8'hA8, ack);
        wt(400);
        write_byte(8'h10, ack);
        check("R10 smbus byte after timeout ignored", ack, 0);
        check("R10 no strobe after timeout", rx_cnt - cnt0, 0);
        bus_stop();
        wt(4);

        // R10: no timeout in I2C mode.
        set_mode(1'b0);
        bus_start();
        write_byte(8'hA8, ack);
        wt(400);
        write_byte(8'h10, ack);
        check("R10 i2c byte after long stall acked", ack, 1);
        wt(2);
        check("R10 i2c stalled byte is memory address", last_first, 1);
        bus_stop();
        wt(4);

        // R12 R11: master reset clears mode and half select.
        set_mode(1'b1);
        bus_start();
        write_byte(8'hAA, ack);
        bus_stop();
        wt(4);
        check("R11 mode set to SMBus", smbus_mode, 1);
        @(negedge clk);
        rst_n = 1'b0;
        wt(3);
        rst_n = 1'b1;
        wt(2);
        check("R12 reset clears mode", smbus_mode, 0);
        check("R12 reset clears half_sel", half_sel, 0);
        check("R12 reset releases sda", sda_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule